// File: doc/BRIEF.md
# Extended Double-VLAN Receive Tag Parser

This block watches received Ethernet frames as they stream past, one byte per cycle, and works out which VLAN tag downstream filtering should use. In extended mode every ordinary data frame is expected to open with an outer tag whose protocol identifier is a programmable 16-bit value. The parser steps over that outer tag, reports the VLAN ID of an inner 0x8100 tag if there is one, and reports the payload ethertype. Link-level control frames carry no tag at all and are accepted in either mode. With extended mode off, the first 0x8100 tag is the filtering tag, as in ordinary single-tag parsing. The frame itself is never altered: the block only observes it.

Results are published once per frame, in the cycle after the last byte, and are held unchanged until the next frame's results replace them. The extended-mode input is sampled on the first byte of each frame. A change made while a frame is in flight only takes effect at the next frame.

The controller walks through eight states. `ST_IDLE` takes byte 0, latches the mode and moves to `ST_MAC`. `ST_MAC` counts the address bytes and moves to `ST_TYPE1`. `ST_TYPE1` reads the first type field and branches:
- to `ST_OUTER_TCI` on an outer-tag match in extended mode;
- to `ST_INNER_TCI` on 0x8100 with the mode off;
- otherwise to `ST_BODY`.

The other states behave as follows:
- `ST_OUTER_TCI` skips the outer control word and moves to `ST_TYPE2`.
- `ST_TYPE2` moves to `ST_INNER_TCI` on 0x8100, otherwise to `ST_BODY`.
- `ST_INNER_TCI` captures the VID and moves to `ST_TYPE3`.
- `ST_TYPE3` captures the payload type and moves to `ST_BODY`.
- `ST_BODY` waits for the last byte.

A last byte in any state returns the controller to `ST_IDLE`.

Top module: `exvlan_rx_parser`

## Requirements
- R1: After reset, `res_valid` and every result output read zero.
- R2: `res_valid` is high for exactly one cycle, the cycle after a byte with `in_valid` and `in_last` is taken. The result outputs change only in that cycle. Idle gaps with `in_valid` low inside a frame do not disturb parsing.
- R3: In extended mode, when the type at bytes 12–13 equals `outer_tpid`, bytes 14–15 are ignored. If bytes 16–17 are 0x8100, `res_inner_present`=1, `res_inner_vid` = the low 12 bits of bytes 18–19, and `res_payload_type` = bytes 20–21.
- R4: In extended mode, when the outer tag matches but bytes 16–17 are not 0x8100, `res_inner_present`=0, `res_inner_vid`=0, and `res_payload_type` = bytes 16–17.
- R5: In extended mode, a frame whose type at bytes 12–13 is neither a control type nor `outer_tpid` sets `res_no_outer_err`=1 with `res_payload_type` = that type and no inner tag.
- R6: Types 0x8808, 0x888E and 0x8809 at bytes 12–13 set `res_ctrl_frame`=1, never set `res_no_outer_err`, and give `res_payload_type` = that type. In extended mode this test is made before the outer-tag comparison.
- R7: With extended mode off, 0x8100 at bytes 12–13 gives `res_inner_present`=1, VID = the low 12 bits of bytes 14–15, and payload type = bytes 16–17. Any other type gives payload type = bytes 12–13 and no error.
- R8: The mode used for a frame is the value of `ext_mode_en` at its byte 0. Changes later in the frame have no effect on that frame.
- R9: A frame that ends before its payload type field is complete sets `res_trunc_err`=1 with every other result output zero.
- R10: Any 16-bit value of `outer_tpid` is honoured as the outer identifier, including 0x8100 and 0x88A8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A frame byte is present on `in_data` |
| in_data | input | 8 | Frame byte, in wire order |
| in_last | input | 1 | Marks the final byte of the frame |
| ext_mode_en | input | 1 | Extended (outer-tag-required) mode, sampled at byte 0 |
| outer_tpid | input | 16 | Programmed outer-tag protocol identifier |
| res_valid | output | 1 | One-cycle pulse: new frame results |
| res_inner_present | output | 1 | A filtering tag was found |
| res_inner_vid | output | 12 | VID for filtering, zero when no tag |
| res_payload_type | output | 16 | First non-tag ethertype |
| res_no_outer_err | output | 1 | Extended mode: required outer tag absent |
| res_trunc_err | output | 1 | Frame ended inside the tag fields |
| res_ctrl_frame | output | 1 | Frame is a link-control frame |

## Verification
The hardest situations to reach are those where the decision depends on state the ports do not show directly. One is a mode flip made in the middle of a frame. Another is a frame that ends exactly on the last byte of a tag field rather than inside it. The stimulus flips `ext_mode_en` partway through chosen frames, in both directions, and cuts frames off at each field boundary in turn. A third case programs `outer_tpid` equal to a control type, so the order of the two tests becomes visible. A behavioural reference parses each frame from its byte queue and is compared with the outputs on every clock, including during idle gaps placed inside frames.

// File: rtl/exvlan_pkg.sv
package exvlan_pkg;

    localparam int BYTE_W = 8;
    localparam int TYPE_W = 16;
    localparam int VID_W  = 12;

    localparam logic [TYPE_W-1:0] TPID_CVLAN = 16'h8100;

    localparam int N_CTRL = 3;
    localparam logic [TYPE_W-1:0] CTRL_TYPES [N_CTRL] = '{16'h8808, 16'h888E, 16'h8809};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_TYPE1,
        ST_OUTER_TCI,
        ST_TYPE2,
        ST_INNER_TCI,
        ST_TYPE3,
        ST_BODY
    } pstate_t;

    typedef struct packed {
        logic              inner;
        logic [VID_W-1:0]  vid;
        logic [TYPE_W-1:0] etype;
        logic              no_outer;
        logic              ctrl;
        logic              trunc;
    } presult_t;

endpackage

// File: rtl/exvlan_byte_pair.sv
module exvlan_byte_pair
    import exvlan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic [2*BYTE_W-1:0] word
);

    logic [BYTE_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_data;
        end
    end

    // High byte is the one taken on the previous valid cycle.
    assign word = {prev_q, in_data};

endmodule

// File: rtl/exvlan_type_classify.sv
module exvlan_type_classify
    import exvlan_pkg::*;
(
    input  logic [TYPE_W-1:0] word,
    output logic              is_ctrl
);

    logic [N_CTRL-1:0] hit;

    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl_cmp
        assign hit[g] = (word == CTRL_TYPES[g]);
    end

    assign is_ctrl = |hit;

endmodule

// File: rtl/exvlan_parse_fsm.sv
module exvlan_parse_fsm
    import exvlan_pkg::*;
#(
    parameter int HDR_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [TYPE_W-1:0] word,
    input  logic              word_is_ctrl,
    input  logic              ext_live,
    input  logic [TYPE_W-1:0] tpid,
    output logic              publish,
    output presult_t          fin
);

    localparam int CNT_W = $clog2(HDR_BYTES + 1);

    pstate_t          state, nxt, nxt_pre;
    logic [CNT_W-1:0] cnt;
    logic             half;
    logic             mode_q;
    presult_t         w_q, w_nxt;
    logic             field_done;
    logic             complete;

    // State register and frame-scope registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            half   <= 1'b0;
            mode_q <= 1'b0;
            w_q    <= '0;
        end else begin
            state <= nxt;
            w_q   <= w_nxt;
            if (state == ST_IDLE && in_valid) begin
                mode_q <= ext_live;
                cnt    <= CNT_W'(1);
            end else if (state == ST_MAC && in_valid) begin
                cnt <= cnt + 1'b1;
            end
            if (state == ST_IDLE || state == ST_MAC || state == ST_BODY) begin
                half <= 1'b0;
            end else begin
                half <= half ^ in_valid;
            end
        end
    end

    assign field_done = in_valid && half;

    // Next state and working results
    always_comb begin
        nxt_pre = state;
        w_nxt   = w_q;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    w_nxt   = '0;
                    nxt_pre = ST_MAC;
                end
            end
            ST_MAC: begin
                if (in_valid && cnt == CNT_W'(HDR_BYTES - 1)) begin
                    nxt_pre = ST_TYPE1;
                end
            end
            ST_TYPE1: begin
                if (field_done) begin
                    if (mode_q) begin
                        if (word_is_ctrl) begin
                            w_nxt.ctrl  = 1'b1;
                            w_nxt.etype = word;
                            nxt_pre     = ST_BODY;
                        end else if (word == tpid) begin
                            nxt_pre = ST_OUTER_TCI;
                        end else begin
                            w_nxt.no_outer = 1'b1;
                            w_nxt.etype    = word;
                            nxt_pre        = ST_BODY;
                        end
                    end else if (word == TPID_CVLAN) begin
                        nxt_pre = ST_INNER_TCI;
                    end else begin
                        w_nxt.ctrl  = word_is_ctrl;
                        w_nxt.etype = word;
                        nxt_pre     = ST_BODY;
                    end
                end
            end
            ST_OUTER_TCI: begin
                if (field_done) begin
                    nxt_pre = ST_TYPE2;
                end
            end
            ST_TYPE2: begin
                if (field_done) begin
                    if (word == TPID_CVLAN) begin
                        nxt_pre = ST_INNER_TCI;
                    end else begin
                        w_nxt.etype = word;
                        nxt_pre     = ST_BODY;
                    end
                end
            end
            ST_INNER_TCI: begin
                if (field_done) begin
                    w_nxt.inner = 1'b1;
                    w_nxt.vid   = word[VID_W-1:0];
                    nxt_pre     = ST_TYPE3;
                end
            end
            ST_TYPE3: begin
                if (field_done) begin
                    w_nxt.etype = word;
                    nxt_pre     = ST_BODY;
                end
            end
            ST_BODY: begin
                nxt_pre = ST_BODY;
            end
            default: begin
                nxt_pre = ST_IDLE;
            end
        endcase
    end

    // Frame end and the published result
    always_comb begin
        publish  = in_valid && in_last;
        nxt      = publish ? ST_IDLE : nxt_pre;
        complete = (nxt_pre == ST_BODY);
        fin      = '0;
        if (complete) begin
            fin       = w_nxt;
            fin.trunc = 1'b0;
        end else begin
            fin.trunc = 1'b1;
        end
    end

endmodule

// File: rtl/exvlan_result_hold.sv
module exvlan_result_hold
    import exvlan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     publish,
    input  presult_t fin,
    output logic     res_valid,
    output presult_t res
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= publish;
            if (publish) begin
                res <= fin;
            end
        end
    end

endmodule

// File: rtl/exvlan_rx_parser.sv
module exvlan_rx_parser
    import exvlan_pkg::*;
#(
    parameter int HDR_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              ext_mode_en,
    input  logic [TYPE_W-1:0] outer_tpid,
    output logic              res_valid,
    output logic              res_inner_present,
    output logic [VID_W-1:0]  res_inner_vid,
    output logic [TYPE_W-1:0] res_payload_type,
    output logic              res_no_outer_err,
    output logic              res_trunc_err,
    output logic              res_ctrl_frame
);

    logic [TYPE_W-1:0] word;
    logic              word_is_ctrl;
    logic              publish;
    presult_t          fin;
    presult_t          res;

    exvlan_byte_pair i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .word     (word)
    );

    exvlan_type_classify i_cls (
        .word    (word),
        .is_ctrl (word_is_ctrl)
    );

    exvlan_parse_fsm #(.HDR_BYTES(HDR_BYTES)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .word         (word),
        .word_is_ctrl (word_is_ctrl),
        .ext_live     (ext_mode_en),
        .tpid         (outer_tpid),
        .publish      (publish),
        .fin          (fin)
    );

    exvlan_result_hold i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .publish   (publish),
        .fin       (fin),
        .res_valid (res_valid),
        .res       (res)
    );

    assign res_inner_present = res.inner;
    assign res_inner_vid     = res.vid;
    assign res_payload_type  = res.etype;
    assign res_no_outer_err  = res.no_outer;
    assign res_trunc_err     = res.trunc;
    assign res_ctrl_frame    = res.ctrl;

endmodule

// File: rtl/exvlan_rx_parser_chk.sv
module exvlan_rx_parser_chk
    import exvlan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              res_valid,
    input logic              res_inner_present,
    input logic [VID_W-1:0]  res_inner_vid,
    input logic [TYPE_W-1:0] res_payload_type,
    input logic              res_no_outer_err,
    input logic              res_trunc_err,
    input logic              res_ctrl_frame
);

    AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_last)); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable({res_inner_present, res_inner_vid, res_payload_type,
                                res_no_outer_err, res_trunc_err, res_ctrl_frame})); // R2

    AST_VID_ZERO_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_inner_present) |-> (res_inner_vid == '0)); // R4

    AST_NO_OUTER_NO_INNER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_no_outer_err) |-> !res_inner_present); // R5

    AST_CTRL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ctrl_frame) |-> !res_no_outer_err); // R6

    AST_TRUNC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_trunc_err) |-> (!res_inner_present && !res_no_outer_err &&
                                          !res_ctrl_frame && res_payload_type == '0)); // R9

endmodule

bind exvlan_rx_parser exvlan_rx_parser_chk i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .in_valid          (in_valid),
    .in_last           (in_last),
    .res_valid         (res_valid),
    .res_inner_present (res_inner_present),
    .res_inner_vid     (res_inner_vid),
    .res_payload_type  (res_payload_type),
    .res_no_outer_err  (res_no_outer_err),
    .res_trunc_err     (res_trunc_err),
    .res_ctrl_frame    (res_ctrl_frame)
);

// File: tb/test_exvlan_rx_parser.sv
`timescale 1ns/1ps
module test_exvlan_rx_parser;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_last, ext_mode_en;
    logic [7:0]  in_data;
    logic [15:0] outer_tpid;
    logic        res_valid, res_inner_present, res_no_outer_err, res_trunc_err, res_ctrl_frame;
    logic [11:0] res_inner_vid;
    logic [15:0] res_payload_type;

    logic        e_valid, e_inner, e_no, e_ctrl, e_trunc;
    logic [11:0] e_vid;
    logic [15:0] e_et;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    logic [7:0] frm[$];

    always #2 clk = ~clk;

    exvlan_rx_parser i_exvlan_rx_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .ext_mode_en(ext_mode_en), .outer_tpid(outer_tpid), .res_valid(res_valid),
        .res_inner_present(res_inner_present), .res_inner_vid(res_inner_vid),
        .res_payload_type(res_payload_type), .res_no_outer_err(res_no_outer_err),
        .res_trunc_err(res_trunc_err), .res_ctrl_frame(res_ctrl_frame)
    );

    function automatic bit is_ctl(input logic [15:0] t);
        return (t == 16'h8808) || (t == 16'h888E) || (t == 16'h8809);
    endfunction

    // Behavioural reference: parse the whole frame by index.
    function automatic void model(input logic [7:0] q[$], input bit ext, input logic [15:0] tp,
                                  output logic inner, output logic [11:0] vid, output logic [15:0] et,
                                  output logic no_outer, output logic ctrl, output logic trunc);
        int n;
        logic [15:0] t1, t2;
        n = q.size();
        inner = 0; vid = 0; et = 0; no_outer = 0; ctrl = 0; trunc = 0;
        if (n < 14) begin trunc = 1; return; end
        t1 = {q[12], q[13]};
        if (ext) begin
            if (is_ctl(t1)) begin
                ctrl = 1; et = t1;
            end else if (t1 == tp) begin
                if (n < 18) begin trunc = 1; return; end
                t2 = {q[16], q[17]};
                if (t2 == 16'h8100) begin
                    if (n < 22) begin trunc = 1; return; end
                    inner = 1; vid = {q[18][3:0], q[19]}; et = {q[20], q[21]};
                end else begin
                    et = t2;
                end
            end else begin
                no_outer = 1; et = t1;
            end
        end else begin
            if (t1 == 16'h8100) begin
                if (n < 18) begin trunc = 1; return; end
                inner = 1; vid = {q[14][3:0], q[15]}; et = {q[16], q[17]};
            end else begin
                et = t1; ctrl = is_ctl(t1);
            end
        end
    endfunction

    task automatic chk();
        checks++;
        if (res_valid !== e_valid || res_inner_present !== e_inner || res_inner_vid !== e_vid ||
            res_payload_type !== e_et || res_no_outer_err !== e_no || res_ctrl_frame !== e_ctrl ||
            res_trunc_err !== e_trunc) begin
            errors++;
            $display("FAIL %s: got v=%0b in=%0b vid=%h et=%h no=%0b ct=%0b tr=%0b exp v=%0b in=%0b vid=%h et=%h no=%0b ct=%0b tr=%0b",
                     cur_req, res_valid, res_inner_present, res_inner_vid, res_payload_type,
                     res_no_outer_err, res_ctrl_frame, res_trunc_err,
                     e_valid, e_inner, e_vid, e_et, e_no, e_ctrl, e_trunc);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            e_valid = 0;
            chk();
        end
    endtask

    task automatic mk(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                      input logic [15:0] w3, input logic [15:0] w4, input int len);
        frm.delete();
        for (int i = 0; i < 12; i++) frm.push_back(8'(i * 17 + 3));
        frm.push_back(w0[15:8]); frm.push_back(w0[7:0]);
        frm.push_back(w1[15:8]); frm.push_back(w1[7:0]);
        frm.push_back(w2[15:8]); frm.push_back(w2[7:0]);
        frm.push_back(w3[15:8]); frm.push_back(w3[7:0]);
        frm.push_back(w4[15:8]); frm.push_back(w4[7:0]);
        for (int i = 0; i < 8; i++) frm.push_back(8'(i + 90));
        while (frm.size() > len) void'(frm.pop_back());
    endtask

    // Drives the current frame; flip_at >= 0 toggles the mode input at that byte.
    task automatic send(input bit ext, input int flip_at, input bit gap);
        logic m_in, m_no, m_ct, m_tr;
        logic [11:0] m_vid;
        logic [15:0] m_et;
        model(frm, ext, outer_tpid, m_in, m_vid, m_et, m_no, m_ct, m_tr);
        ext_mode_en = ext;
        for (int i = 0; i < frm.size(); i++) begin
            in_valid = 1;
            in_data  = frm[i];
            in_last  = (i == frm.size() - 1);
            if (i == flip_at) ext_mode_en = ~ext;
            @(negedge clk);
            if (in_last) begin
                e_valid = 1; e_inner = m_in; e_vid = m_vid; e_et = m_et;
                e_no = m_no; e_ctrl = m_ct; e_trunc = m_tr;
            end else begin
                e_valid = 0;
            end
            chk();
            if (gap && (i % 3 == 1) && !in_last) begin
                in_valid = 0; in_last = 0;
                @(negedge clk);
                e_valid = 0;
                chk();
            end
        end
        in_valid = 0; in_last = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no completion, exp finish before limit");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; in_last = 0; in_data = 0; ext_mode_en = 0; outer_tpid = 16'h9100;
        e_valid = 0; e_inner = 0; e_vid = 0; e_et = 0; e_no = 0; e_ctrl = 0; e_trunc = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1"; chk();
        rst_n = 1;
        idle(2);

        // R3: outer + inner tag, PCP bits must not leak into VID
        cur_req = "R3";
        mk(16'h9100, 16'h5555, 16'h8100, 16'hA123, 16'h0800, 30); send(1, -1, 0);
        // R2: idle gaps inside a frame, back to back frames
        cur_req = "R2";
        mk(16'h9100, 16'h0001, 16'h8100, 16'h0FFE, 16'h86DD, 26); send(1, -1, 1);
        mk(16'h9100, 16'h0001, 16'h8100, 16'h0002, 16'h0806, 22); send(1, -1, 0);
        idle(3);
        // R4: outer tag only
        cur_req = "R4";
        mk(16'h9100, 16'hEEEE, 16'h86DD, 16'h1111, 16'h2222, 24); send(1, -1, 0);
        // R5: missing outer tag
        cur_req = "R5";
        mk(16'h0800, 16'h8100, 16'h0123, 16'h0800, 16'h0000, 24); send(1, -1, 0);
        mk(16'h8100, 16'h0123, 16'h0800, 16'h0000, 16'h0000, 20); send(1, -1, 1);
        // R6: control frames in both modes, and ordering against outer match
        cur_req = "R6";
        mk(16'h8808, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 20); send(1, -1, 0);
        mk(16'h888E, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 14); send(1, -1, 0);
        mk(16'h8809, 16'h0101, 16'h0000, 16'h0000, 16'h0000, 20); send(0, -1, 0);
        outer_tpid = 16'h8809;
        mk(16'h8809, 16'h0101, 16'h8100, 16'h0005, 16'h0800, 24); send(1, -1, 0);
        outer_tpid = 16'h9100;
        idle(1);
        // R7: mode off
        cur_req = "R7";
        mk(16'h8100, 16'h2FFF, 16'h0806, 16'h0000, 16'h0000, 22); send(0, -1, 0);
        mk(16'h0800, 16'h4500, 16'h0000, 16'h0000, 16'h0000, 20); send(0, -1, 0);
        mk(16'h9100, 16'h0010, 16'h8100, 16'h0020, 16'h0800, 24); send(0, -1, 1);
        // R8: mid-frame mode flips have no effect
        cur_req = "R8";
        mk(16'h0800, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 20); send(1, 4, 0);
        idle(1);
        mk(16'h0800, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 20); send(0, 12, 0);
        idle(1);
        mk(16'h8100, 16'h0333, 16'h8100, 16'h0444, 16'h0800, 24); send(0, 13, 0);
        idle(1);
        // R9: truncation at every field boundary
        cur_req = "R9";
        mk(16'h9100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1);  send(1, -1, 0);
        mk(16'h9100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 13); send(1, -1, 0);
        mk(16'h9100, 16'h0000, 16'h8100, 16'h0000, 16'h0000, 14); send(1, -1, 0);
        mk(16'h9100, 16'h0000, 16'h8100, 16'h0000, 16'h0000, 17); send(1, -1, 1);
        mk(16'h9100, 16'h0000, 16'h8100, 16'h0777, 16'h0800, 21); send(1, -1, 0);
        mk(16'h9100, 16'h0000, 16'h8100, 16'h0777, 16'h0800, 22); send(1, -1, 0);
        mk(16'h8100, 16'h0123, 16'h0800, 16'h0000, 16'h0000, 15); send(0, -1, 0);
        mk(16'h0800, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 14); send(1, -1, 0);
        idle(2);
        // R10: arbitrary outer identifiers
        cur_req = "R10";
        outer_tpid = 16'h8100;
        mk(16'h8100, 16'h0FFF, 16'h8100, 16'h0ABC, 16'h0800, 24); send(1, -1, 0);
        outer_tpid = 16'h88A8;
        mk(16'h88A8, 16'h0001, 16'h8100, 16'hF00D, 16'h86DD, 24); send(1, -1, 0);
        mk(16'h9100, 16'h0001, 16'h8100, 16'h0002, 16'h0800, 24); send(1, -1, 0);
        outer_tpid = 16'h0000;
        mk(16'h0000, 16'h0001, 16'h0800, 16'h0000, 16'h0000, 20); send(1, -1, 0);
        idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule